// File: doc/BRIEF.md
# Way-Partitioned Last-Level Cache with Direct I/O Placement

This block is a set-associative shared cache that serves two kinds of requester. Core requesters issue loads and stores. A single I/O requester issues inbound writes and outbound reads. Inbound I/O writes are placed straight into the cache, not sent to memory. Each access moves exactly one whole line.

Every requester owns a way mask that limits where it may install new lines. Lookups from any requester still search every way of the set, so a line that one requester installed can be hit and updated by any other. An I/O read that misses is served from memory and leaves the cache unchanged. Mask writes are checked: a mask must be non-empty and its set bits must be consecutive. Event counters count core references and misses for each core, and count I/O write hits and misses for the whole block. Lines that must leave the cache, and lines that must be fetched, go through one backing-memory request channel and one response channel, both with valid/ready handshakes.

Top module: `wp_cache`

## Requirements
- R1: An I/O write (`req_is_io`=1, `req_write`=1) whose address matches a valid line in any way of its set overwrites that line in place and marks it dirty. It adds one to the I/O hit counter and issues no memory transaction.
- R2: An I/O write that misses installs the line, dirty, only into a way enabled in the I/O mask, and adds one to the I/O miss counter. If the chosen victim is valid and dirty, it is first written to memory. No memory read is made.
- R3: After reset, the I/O mask enables exactly the two highest-numbered ways, every core mask enables all ways, all counters read zero, and no line is valid.
- R4: An I/O read that hits returns the cached data with no memory transaction. An I/O read that misses returns the memory data and installs nothing, so repeating the read fetches from memory again.
- R5: A core load or store hits and uses a matching line in any way. A core miss installs the line only into a way enabled in that core's own mask.
- R6: A mask write (`cfg_we`) to a selector below the core count addresses that core's mask, and any larger selector addresses the I/O mask. A non-empty mask whose set bits are consecutive is taken. Any other mask is rejected and the old mask is kept. `cfg_mask_rd` always shows the mask chosen by `cfg_sel`.
- R7: Each accepted core request adds one to that core's reference counter, and adds one to its miss counter when it misses. Only I/O writes change the I/O hit and miss counters.
- R8: The victim is chosen among the allowed ways. The lowest-numbered invalid allowed way is taken first. If every allowed way is valid, the first allowed way found scanning upward from the set's round-robin pointer (with wrap-around) is taken. After each install, the pointer moves to the way just after the installed one.
- R9: Only one request is handled at a time. `req_ready` is low while a writeback or a memory read is in flight, and a memory request holds its address until accepted. Every accepted request ends with `rsp_valid` high for one cycle, carrying the read data for loads and I/O reads.
- R10: A core load miss installs the fetched line clean. A core store miss installs the store data dirty, with no fetch. A store hit marks the line dirty. An evicted dirty line is written back, and an evicted clean line is dropped silently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_is_io | input | 1 | 1 = I/O requester, 0 = core requester |
| req_core | input | CORE_W | Core index of a core request |
| req_write | input | 1 | 1 = store / inbound write, 0 = load / outbound read |
| req_addr | input | ADDR_W | Line address (low SET_W bits select the set) |
| req_wdata | input | DATA_W | Write line data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data on completion |
| cfg_we | input | 1 | Mask write strobe |
| cfg_sel | input | SEL_W | Mask selector (core index, or I/O when at or above the core count) |
| cfg_mask | input | NUM_WAYS | Mask value to write |
| cfg_mask_rd | output | NUM_WAYS | Current mask at cfg_sel |
| cnt_core | input | CORE_W | Core whose counters are shown |
| core_ref_cnt | output | CNT_W | Reference count of cnt_core |
| core_miss_cnt | output | CNT_W | Miss count of cnt_core |
| io_hit_cnt | output | CNT_W | I/O write hit count |
| io_miss_cnt | output | CNT_W | I/O write miss count |
| mem_req_valid | output | 1 | Memory request offered |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = writeback, 0 = line read |
| mem_req_addr | output | ADDR_W | Memory line address |
| mem_req_wdata | output | DATA_W | Writeback data |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | DATA_W | Returned line |

## Verification
The bench builds the cache with 4 ways, 4 sets, 2 cores, an 8-bit line address and 16-bit lines. With these sizes, a few requests to one set fill it. This makes victim choice, pointer wrap-around, and dirty versus clean eviction easy to reach in a short directed run. The I/O mask then covers half of the set and a core mask can be cut to the other half, so the bench can show that installs by one requester leave the other requester's ways untouched. It does this by watching memory read and writeback traffic at the ports.

// File: rtl/wp_cache_pkg.sv
package wp_cache_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WBACK = 2'd1,
        ST_MREQ  = 2'd2,
        ST_MWAIT = 2'd3
    } state_e;

    typedef enum logic [1:0] {
        OP_CLOAD  = 2'd0,
        OP_CSTORE = 2'd1,
        OP_IOWR   = 2'd2,
        OP_IORD   = 2'd3
    } op_e;

endpackage

// File: rtl/wp_mask_ok.sv
// Legal-mask test: non-zero with a single run of ones.
module wp_mask_ok #(
    parameter int NUM_WAYS = 8
) (
    input  logic [NUM_WAYS-1:0] mask,
    output logic                ok
);
    logic [NUM_WAYS-1:0] lowest;
    logic [NUM_WAYS:0]   carried;

    always_comb begin
        lowest  = mask & (~mask + 1'b1);
        // adding the lowest set bit clears a single run completely
        carried = {1'b0, mask} + {1'b0, lowest};
        ok      = (mask != '0) && ((carried[NUM_WAYS-1:0] & mask) == '0);
    end
endmodule

// File: rtl/wp_way_match.sv
// Tag compare across all ways of one set.
module wp_way_match #(
    parameter int NUM_WAYS = 8,
    parameter int TAG_W    = 16,
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS-1:0]            line_valid,
    input  logic [NUM_WAYS-1:0][TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0]               look_tag,
    output logic                           hit,
    output logic [WAY_W-1:0]               hit_way
);
    logic [NUM_WAYS-1:0] match;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
        assign match[w] = line_valid[w] && (line_tag[w] == look_tag);
    end

    always_comb begin
        hit     = |match;
        hit_way = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (match[w]) hit_way = WAY_W'(w);
        end
    end
endmodule

// File: rtl/wp_victim_sel.sv
// Victim choice: lowest invalid allowed way, else round-robin over allowed ways.
module wp_victim_sel #(
    parameter int NUM_WAYS = 8,
    localparam int WAY_W   = $clog2(NUM_WAYS)
) (
    input  logic [NUM_WAYS-1:0] allow,
    input  logic [NUM_WAYS-1:0] line_valid,
    input  logic [WAY_W-1:0]    rr_ptr,
    output logic [WAY_W-1:0]    victim
);
    logic [NUM_WAYS-1:0] free_ok;
    logic [WAY_W-1:0]    free_way;
    logic [WAY_W-1:0]    rr_way;

    always_comb begin
        free_ok  = allow & ~line_valid;
        free_way = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (free_ok[w]) free_way = WAY_W'(w);
        end
        rr_way = '0;
        // scan downward so the smallest step from the pointer wins
        for (int k = NUM_WAYS - 1; k >= 0; k--) begin
            if (allow[(int'(rr_ptr) + k) % NUM_WAYS]) begin
                rr_way = WAY_W'((int'(rr_ptr) + k) % NUM_WAYS);
            end
        end
        victim = (free_ok != '0) ? free_way : rr_way;
    end
endmodule

// File: rtl/wp_cache.sv
module wp_cache
    import wp_cache_pkg::*;
#(
    parameter int NUM_WAYS  = 8,
    parameter int NUM_SETS  = 16,
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 20,
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 16,
    localparam int WAY_W    = $clog2(NUM_WAYS),
    localparam int SET_W    = $clog2(NUM_SETS),
    localparam int TAG_W    = ADDR_W - SET_W,
    localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int SEL_W    = $clog2(NUM_CORES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_is_io,
    input  logic [CORE_W-1:0]   req_core,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    input  logic                cfg_we,
    input  logic [SEL_W-1:0]    cfg_sel,
    input  logic [NUM_WAYS-1:0] cfg_mask,
    output logic [NUM_WAYS-1:0] cfg_mask_rd,
    input  logic [CORE_W-1:0]   cnt_core,
    output logic [CNT_W-1:0]    core_ref_cnt,
    output logic [CNT_W-1:0]    core_miss_cnt,
    output logic [CNT_W-1:0]    io_hit_cnt,
    output logic [CNT_W-1:0]    io_miss_cnt,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic                mem_req_write,
    output logic [ADDR_W-1:0]   mem_req_addr,
    output logic [DATA_W-1:0]   mem_req_wdata,
    input  logic                mem_rsp_valid,
    input  logic [DATA_W-1:0]   mem_rsp_rdata
);

    localparam logic [NUM_WAYS-1:0] IO_MASK_RST = ~({NUM_WAYS{1'b1}} >> 2);
    localparam logic [NUM_WAYS-1:0] CORE_MASK_RST = {NUM_WAYS{1'b1}};
    localparam int IO_IDX = NUM_CORES;

    typedef struct packed {
        state_e                                       st;
        op_e                                          op;
        logic [CORE_W-1:0]                            core;
        logic [ADDR_W-1:0]                            addr;
        logic [DATA_W-1:0]                            wdata;
        logic [WAY_W-1:0]                             vway;
        logic                                         rsp_v;
        logic [DATA_W-1:0]                            rsp_d;
        logic [NUM_SETS-1:0][NUM_WAYS-1:0]            valid;
        logic [NUM_SETS-1:0][NUM_WAYS-1:0]            dirty;
        logic [NUM_SETS-1:0][NUM_WAYS-1:0][TAG_W-1:0] tags;
        logic [NUM_SETS-1:0][NUM_WAYS-1:0][DATA_W-1:0] data;
        logic [NUM_SETS-1:0][WAY_W-1:0]               ptr;
        logic [NUM_CORES:0][NUM_WAYS-1:0]             masks;
        logic [NUM_CORES-1:0][CNT_W-1:0]              c_ref;
        logic [NUM_CORES-1:0][CNT_W-1:0]              c_miss;
        logic [CNT_W-1:0]                             io_hit;
        logic [CNT_W-1:0]                             io_miss;
    } regs_t;

    regs_t q, d;

    // request decode
    logic [SET_W-1:0]    in_set;
    logic [TAG_W-1:0]    in_tag;
    logic [CORE_W-1:0]   core_idx;
    op_e                 in_op;
    logic [NUM_WAYS-1:0] in_allow;
    logic                in_hit;
    logic [WAY_W-1:0]    in_hit_way;
    logic [WAY_W-1:0]    in_victim;

    // pending request decode
    logic [SET_W-1:0]    p_set;
    logic [TAG_W-1:0]    p_tag;

    // mask programming
    logic [SEL_W-1:0]    cfg_idx;
    logic [CORE_W-1:0]   cnt_idx;
    logic                cfg_legal;

    // line write port
    logic                wr_en;
    logic [SET_W-1:0]    wr_set;
    logic [WAY_W-1:0]    wr_way;
    logic [TAG_W-1:0]    wr_tag;
    logic [DATA_W-1:0]   wr_data;
    logic                wr_dirty;
    logic                wr_bump;

    assign in_set   = req_addr[SET_W-1:0];
    assign in_tag   = req_addr[ADDR_W-1:SET_W];
    assign p_set    = q.addr[SET_W-1:0];
    assign p_tag    = q.addr[ADDR_W-1:SET_W];
    assign core_idx = (int'(req_core) < NUM_CORES) ? req_core : '0;
    assign cnt_idx  = (int'(cnt_core) < NUM_CORES) ? cnt_core : '0;
    assign cfg_idx  = (int'(cfg_sel) < NUM_CORES) ? cfg_sel : SEL_W'(IO_IDX);
    assign in_op    = req_is_io ? (req_write ? OP_IOWR : OP_IORD)
                                : (req_write ? OP_CSTORE : OP_CLOAD);
    assign in_allow = req_is_io ? q.masks[IO_IDX] : q.masks[core_idx];

    wp_mask_ok #(.NUM_WAYS(NUM_WAYS)) i_mask_ok (
        .mask (cfg_mask),
        .ok   (cfg_legal)
    );

    wp_way_match #(.NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W)) i_way_match (
        .line_valid (q.valid[in_set]),
        .line_tag   (q.tags[in_set]),
        .look_tag   (in_tag),
        .hit        (in_hit),
        .hit_way    (in_hit_way)
    );

    wp_victim_sel #(.NUM_WAYS(NUM_WAYS)) i_victim_sel (
        .allow      (in_allow),
        .line_valid (q.valid[in_set]),
        .rr_ptr     (q.ptr[in_set]),
        .victim     (in_victim)
    );

    always_comb begin
        d       = q;
        d.rsp_v = 1'b0;

        wr_en    = 1'b0;
        wr_set   = in_set;
        wr_way   = in_hit_way;
        wr_tag   = in_tag;
        wr_data  = req_wdata;
        wr_dirty = 1'b1;
        wr_bump  = 1'b0;

        if (cfg_we && cfg_legal) begin
            d.masks[cfg_idx] = cfg_mask;
        end

        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.op    = in_op;
                    d.core  = core_idx;
                    d.addr  = req_addr;
                    d.wdata = req_wdata;
                    d.vway  = in_victim;
                    if (!req_is_io) begin
                        d.c_ref[core_idx] = q.c_ref[core_idx] + 1'b1;
                        if (!in_hit) d.c_miss[core_idx] = q.c_miss[core_idx] + 1'b1;
                    end else if (req_write) begin
                        if (in_hit) d.io_hit  = q.io_hit + 1'b1;
                        else        d.io_miss = q.io_miss + 1'b1;
                    end
                    if (in_hit) begin
                        d.rsp_v = 1'b1;
                        if (req_write) begin
                            wr_en   = 1'b1;
                            d.rsp_d = '0;
                        end else begin
                            d.rsp_d = q.data[in_set][in_hit_way];
                        end
                    end else if (in_op == OP_IORD) begin
                        d.st = ST_MREQ;
                    end else if (q.valid[in_set][in_victim] && q.dirty[in_set][in_victim]) begin
                        d.st = ST_WBACK;
                    end else if (in_op == OP_CLOAD) begin
                        d.st = ST_MREQ;
                    end else begin
                        wr_en   = 1'b1;
                        wr_way  = in_victim;
                        wr_bump = 1'b1;
                        d.rsp_v = 1'b1;
                        d.rsp_d = '0;
                    end
                end
            end
            ST_WBACK: begin
                if (mem_req_ready) begin
                    if (q.op == OP_CLOAD) begin
                        d.st = ST_MREQ;
                    end else begin
                        wr_en   = 1'b1;
                        wr_set  = p_set;
                        wr_way  = q.vway;
                        wr_tag  = p_tag;
                        wr_data = q.wdata;
                        wr_bump = 1'b1;
                        d.rsp_v = 1'b1;
                        d.rsp_d = '0;
                        d.st    = ST_IDLE;
                    end
                end
            end
            ST_MREQ: begin
                if (mem_req_ready) d.st = ST_MWAIT;
            end
            ST_MWAIT: begin
                if (mem_rsp_valid) begin
                    d.rsp_v = 1'b1;
                    d.rsp_d = mem_rsp_rdata;
                    d.st    = ST_IDLE;
                    if (q.op == OP_CLOAD) begin
                        wr_en    = 1'b1;
                        wr_set   = p_set;
                        wr_way   = q.vway;
                        wr_tag   = p_tag;
                        wr_data  = mem_rsp_rdata;
                        wr_dirty = 1'b0;
                        wr_bump  = 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (wr_en) begin
            d.valid[wr_set][wr_way] = 1'b1;
            d.dirty[wr_set][wr_way] = wr_dirty;
            d.tags[wr_set][wr_way]  = wr_tag;
            d.data[wr_set][wr_way]  = wr_data;
            if (wr_bump) begin
                d.ptr[wr_set] = (wr_way == WAY_W'(NUM_WAYS - 1)) ? '0 : wr_way + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
            for (int c = 0; c < NUM_CORES; c++) begin
                q.masks[c] <= CORE_MASK_RST;
            end
            q.masks[IO_IDX] <= IO_MASK_RST;
        end else begin
            q <= d;
        end
    end

    assign req_ready     = (q.st == ST_IDLE);
    assign rsp_valid     = q.rsp_v;
    assign rsp_rdata     = q.rsp_d;
    assign cfg_mask_rd   = q.masks[cfg_idx];
    assign core_ref_cnt  = q.c_ref[cnt_idx];
    assign core_miss_cnt = q.c_miss[cnt_idx];
    assign io_hit_cnt    = q.io_hit;
    assign io_miss_cnt   = q.io_miss;
    assign mem_req_valid = (q.st == ST_WBACK) || (q.st == ST_MREQ);
    assign mem_req_write = (q.st == ST_WBACK);
    assign mem_req_addr  = (q.st == ST_WBACK) ? {q.tags[p_set][q.vway], p_set} : q.addr;
    assign mem_req_wdata = q.data[p_set][q.vway];

endmodule

// File: rtl/wp_cache_chk.sv
module wp_cache_chk #(
    parameter int NUM_WAYS  = 8,
    parameter int NUM_CORES = 4,
    parameter int ADDR_W    = 20,
    parameter int CNT_W     = 16,
    localparam int SEL_W    = $clog2(NUM_CORES + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_ready,
    input logic                req_is_io,
    input logic                req_write,
    input logic                cfg_we,
    input logic [SEL_W-1:0]    cfg_sel,
    input logic [NUM_WAYS-1:0] cfg_mask,
    input logic [NUM_WAYS-1:0] cfg_mask_rd,
    input logic [CNT_W-1:0]    io_hit_cnt,
    input logic [CNT_W-1:0]    io_miss_cnt,
    input logic                mem_req_valid,
    input logic                mem_req_ready,
    input logic                mem_req_write,
    input logic [ADDR_W-1:0]   mem_req_addr
);
    logic [NUM_WAYS+1:0] in_ext, rd_ext;
    logic                in_single_run, rd_single_run;
    logic [CNT_W-1:0]    hit_prev, miss_prev, hit_step, miss_step;

    // one run of ones means exactly two edges once padded by zeros
    assign in_ext        = {1'b0, cfg_mask, 1'b0};
    assign rd_ext        = {1'b0, cfg_mask_rd, 1'b0};
    assign in_single_run = ($countones(in_ext ^ (in_ext >> 1)) == 2);
    assign rd_single_run = ($countones(rd_ext ^ (rd_ext >> 1)) == 2);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_prev  <= '0;
            miss_prev <= '0;
        end else begin
            hit_prev  <= io_hit_cnt;
            miss_prev <= io_miss_cnt;
        end
    end
    assign hit_step  = io_hit_cnt - hit_prev;
    assign miss_step = io_miss_cnt - miss_prev;

    p_busy_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    p_mem_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

    p_mask_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !in_single_run) |=> (!$stable(cfg_sel) || $stable(cfg_mask_rd)));

    p_mask_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_single_run);

    p_io_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, hit_step} + {1'b0, miss_step}) <= 1);

    p_io_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((hit_step != '0) || (miss_step != '0)) |->
            $past(req_valid && req_ready && req_is_io && req_write));

endmodule

bind wp_cache wp_cache_chk #(
    .NUM_WAYS  (NUM_WAYS),
    .NUM_CORES (NUM_CORES),
    .ADDR_W    (ADDR_W),
    .CNT_W     (CNT_W)
) i_wp_cache_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_is_io     (req_is_io),
    .req_write     (req_write),
    .cfg_we        (cfg_we),
    .cfg_sel       (cfg_sel),
    .cfg_mask      (cfg_mask),
    .cfg_mask_rd   (cfg_mask_rd),
    .io_hit_cnt    (io_hit_cnt),
    .io_miss_cnt   (io_miss_cnt),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr)
);

// File: tb/test_wp_cache.sv
`timescale 1ns/1ps
module test_wp_cache;
    localparam int W = 4, S = 4, NC = 2, AW = 8, DW = 16, CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_is_io = 1'b0;
    logic [0:0]    req_core = '0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [W-1:0]  cfg_mask = '0;
    logic [W-1:0]  cfg_mask_rd;
    logic [0:0]    cnt_core = '0;
    logic [CW-1:0] core_ref_cnt, core_miss_cnt, io_hit_cnt, io_miss_cnt;
    logic          mem_req_valid;
    logic          mem_req_ready = 1'b1;
    logic          mem_req_write;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_wdata;
    logic          mem_rsp_valid = 1'b0;
    logic [DW-1:0] mem_rsp_rdata = '0;

    int checks = 0;
    int fails = 0;
    int rd_cnt = 0;
    int wb_cnt = 0;
    logic [DW-1:0] mem [256];

    always #10 clk = ~clk;

    wp_cache #(
        .NUM_WAYS(W), .NUM_SETS(S), .NUM_CORES(NC),
        .ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)
    ) i_wp_cache (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_is_io(req_is_io),
        .req_core(req_core), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_mask(cfg_mask), .cfg_mask_rd(cfg_mask_rd),
        .cnt_core(cnt_core), .core_ref_cnt(core_ref_cnt), .core_miss_cnt(core_miss_cnt),
        .io_hit_cnt(io_hit_cnt), .io_miss_cnt(io_miss_cnt),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata)
    );

    // vector: {is_io, core, write, check_rdata, addr[8], wdata[16], expected[16]}
    localparam int NV = 11;
    localparam logic [43:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b0, 1'b1, 8'h10, 16'h0000, 16'hA010}, // R10 load miss fill
        {1'b0, 1'b0, 1'b0, 1'b1, 8'h10, 16'h0000, 16'hA010}, // R5 load hit
        {1'b0, 1'b0, 1'b1, 1'b0, 8'h10, 16'h1234, 16'h0000}, // R10 store hit
        {1'b0, 1'b1, 1'b0, 1'b1, 8'h10, 16'h0000, 16'h1234}, // R5 other core hits
        {1'b1, 1'b0, 1'b1, 1'b0, 8'h20, 16'h5555, 16'h0000}, // R2 io write miss
        {1'b0, 1'b0, 1'b0, 1'b1, 8'h20, 16'h0000, 16'h5555}, // R5 core sees injected line
        {1'b1, 1'b0, 1'b1, 1'b0, 8'h20, 16'h6666, 16'h0000}, // R1 io write hit
        {1'b0, 1'b1, 1'b0, 1'b1, 8'h20, 16'h0000, 16'h6666}, // R1 updated in place
        {1'b1, 1'b0, 1'b0, 1'b1, 8'h30, 16'h0000, 16'hA030}, // R4 io read miss
        {1'b1, 1'b0, 1'b0, 1'b1, 8'h10, 16'h0000, 16'h1234}, // R4 io read hit
        {1'b0, 1'b0, 1'b0, 1'b1, 8'h31, 16'h0000, 16'hA031}  // R10 other set
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_req(input logic io, input logic core, input logic wr,
                          input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          output logic [DW-1:0] rd, output logic busy);
        @(negedge clk);
        req_valid = 1'b1; req_is_io = io; req_core = core;
        req_write = wr; req_addr = a; req_wdata = wd;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        busy = 1'b0;
        while (!rsp_valid) begin
            if (!req_ready) busy = 1'b1;
            @(negedge clk);
        end
        rd = rsp_rdata;
    endtask

    task automatic write_mask(input logic [1:0] sel, input logic [W-1:0] m);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_mask = m;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // memory model
    initial begin
        logic          pend;
        logic [DW-1:0] pend_data;
        pend = 1'b0;
        pend_data = '0;
        for (int i = 0; i < 256; i++) mem[i] = 16'hA000 + 16'(i);
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (pend) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_rdata = pend_data;
                pend = 1'b0;
            end
            if (mem_req_valid && mem_req_ready) begin
                if (mem_req_write) begin
                    mem[mem_req_addr] = mem_req_wdata;
                    wb_cnt++;
                end else begin
                    rd_cnt++;
                    pend = 1'b1;
                    pend_data = mem[mem_req_addr];
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R9 actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [DW-1:0] rd;
        logic busy;
        int rd0, wb0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R3 reset state
        cfg_sel = 2'd2;
        #1 check("R3 io mask", 32'(cfg_mask_rd), 32'h0C);
        cfg_sel = 2'd0;
        #1 check("R3 core mask", 32'(cfg_mask_rd), 32'h0F);
        check("R3 counters", {core_ref_cnt, core_miss_cnt, io_hit_cnt, io_miss_cnt}, 32'h0);
        check("R9 idle ready", {31'h0, req_ready}, 32'h1);
        check("R9 no mem req", {31'h0, mem_req_valid}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            do_req(VEC[i][43], VEC[i][42], VEC[i][41], VEC[i][39:32], VEC[i][31:16], rd, busy);
            if (VEC[i][40]) check($sformatf("R5/R10/R1/R4 vector %0d rdata", i), 32'(rd), 32'(VEC[i][15:0]));
        end
        @(negedge clk);
        check("R9 single pulse", {31'h0, rsp_valid}, 32'h0);

        // R7 counters after table
        cnt_core = 1'b0;
        #1 check("R7 core0 ref/miss", {core_ref_cnt, core_miss_cnt}, {8'd5, 8'd2});
        cnt_core = 1'b1;
        #1 check("R7 core1 ref/miss", {core_ref_cnt, core_miss_cnt}, {8'd2, 8'd0});
        check("R7 io hit/miss", {io_hit_cnt, io_miss_cnt}, {8'd1, 8'd1});
        check("R4 memory reads so far", 32'(rd_cnt), 32'd3);

        // R4 read miss does not allocate
        do_req(1'b1, 1'b0, 1'b0, 8'h30, 16'h0, rd, busy);
        check("R4 repeated io read data", 32'(rd), 32'hA030);
        check("R4 repeated io read fetched", 32'(rd_cnt), 32'd4);

        // R6 mask programming
        write_mask(2'd0, 4'b0101);
        check("R6 non-contiguous rejected", 32'(cfg_mask_rd), 32'h0F);
        write_mask(2'd0, 4'b0000);
        check("R6 empty rejected", 32'(cfg_mask_rd), 32'h0F);
        write_mask(2'd0, 4'b0011);
        check("R6 contiguous taken", 32'(cfg_mask_rd), 32'h03);
        cfg_sel = 2'd3;
        #1 check("R6 high selector reads io mask", 32'(cfg_mask_rd), 32'h0C);

        // R5/R8 core fill confined to ways 0..1 of set 0
        do_req(1'b0, 1'b0, 1'b0, 8'h40, 16'h0, rd, busy);
        check("R8 free allowed way fill", 32'(rd), 32'hA040);
        do_req(1'b0, 1'b0, 1'b0, 8'h80, 16'h0, rd, busy);
        check("R10 dirty victim written back", {16'(wb_cnt), mem[8'h10]}, {16'd1, 16'h1234});
        check("R8 round-robin fill data", 32'(rd), 32'hA080);
        rd0 = rd_cnt;
        do_req(1'b1, 1'b0, 1'b0, 8'h20, 16'h0, rd, busy);
        check("R5 io line outside core mask kept", {16'(rd_cnt - rd0), rd}, {16'd0, 16'h6666});

        // R2 io install into io ways only, dirty victim first
        rd0 = rd_cnt; wb0 = wb_cnt;
        do_req(1'b1, 1'b0, 1'b1, 8'h24, 16'h7777, rd, busy);
        check("R2 free io way no traffic", {16'(rd_cnt - rd0), 16'(wb_cnt - wb0)}, 32'h0);
        do_req(1'b1, 1'b0, 1'b1, 8'h28, 16'h8888, rd, busy);
        check("R2 dirty io victim written back", {16'(wb_cnt - wb0), mem[8'h20]}, {16'd1, 16'h6666});
        check("R2 no memory read on io write", 32'(rd_cnt - rd0), 32'd0);
        check("R7 io miss count", {io_hit_cnt, io_miss_cnt}, {8'd1, 8'd3});
        do_req(1'b0, 1'b1, 1'b0, 8'h24, 16'h0, rd, busy);
        check("R2 installed io line hits", {16'(rd_cnt - rd0), rd}, {16'd0, 16'h7777});
        do_req(1'b0, 1'b1, 1'b0, 8'h40, 16'h0, rd, busy);
        check("R2 core way untouched by io fill", {16'(rd_cnt - rd0), rd}, {16'd0, 16'hA040});

        // R10 refetch of written-back line, then clean eviction
        do_req(1'b0, 1'b1, 1'b0, 8'h20, 16'h0, rd, busy);
        check("R10 refetch returns written-back data", 32'(rd), 32'h6666);
        check("R9 requester stalled during miss", {31'h0, busy}, 32'h1);
        wb0 = wb_cnt;
        do_req(1'b0, 1'b1, 1'b0, 8'hC0, 16'h0, rd, busy);
        check("R10 clean victim dropped", {16'(wb_cnt - wb0), rd}, {16'd0, 16'hA0C0});
        cnt_core = 1'b1;
        #1 check("R7 core1 final ref/miss", {core_ref_cnt, core_miss_cnt}, {8'd6, 8'd2});
        cnt_core = 1'b0;
        #1 check("R7 core0 final ref/miss", {core_ref_cnt, core_miss_cnt}, {8'd7, 8'd4});

        finish_run();
    end
endmodule